// File: doc/BRIEF.md
# Hex Text Record Memory Loader

The block sits behind a character source and turns lines of hexadecimal text into byte writes on a memory port. Characters arrive one per accepted valid/ready beat. A separate end-of-line flag marks beats that close a line, and the character value carried on such a beat is not used. Each record takes two lines. The header line holds the load address and the byte count, followed by free comment. The data line holds the bytes, each followed by one space, followed by free comment.

For every data byte the loader issues a one-cycle write to a byte-wide memory port. The first byte goes to the record address and each following byte goes to the next higher address. A one-cycle pulse marks each record that completes. Any departure from the record layout raises a one-cycle error pulse. After an error the loader drops the rest of the line and treats the next line as a new header. Typical use is loading a code or data image into RAM from a text stream received over a serial link.

Top module: `hexrec_loader`

## Requirements
- R1: While rst_ni is low, mem_we_o, rec_done_o and rec_err_o are low and ch_ready_o is high. After reset the parser expects the first address digit of a new record, even if reset arrived in the middle of a record.
- R2: The header begins with the address as exactly 4 hex digits, most significant digit first. The first data byte is written to that address and each later byte to the address one higher, wrapping modulo 2^16.
- R3: The header line is the address, one space (0x20), one hex count digit, then any characters up to the line end. Those trailing characters are ignored. The data bytes start on the following line.
- R4: A data byte is two hex digits, high nibble first. One cycle after the second digit is accepted, mem_we_o is high for exactly one cycle, with mem_addr_o set to the target address and mem_data_o set to the byte.
- R5: Each data byte must be followed by one space. One cycle after the space that follows the last byte is accepted, rec_done_o pulses for one cycle. The rest of that line is ignored: it causes no writes and no errors.
- R6: A count of 0 makes rec_done_o pulse one cycle after the header's line end. No write is made, and the next line is parsed as a new header.
- R7: Hex conversion maps '0'-'9' (0x30-0x39) to 0-9 and 'A'-'F' (0x41-0x46) to 10-15. Every other code is invalid, including ':' to '@' and lowercase letters. An invalid code where a digit is expected raises rec_err_o one cycle later, and the rest of the line is dropped.
- R8: A character other than a space where a separator space is expected raises rec_err_o one cycle later, and the rest of the line is dropped.
- R9: A line end that arrives before the record is complete raises rec_err_o one cycle later. This covers a line end inside the address, before the count, inside a data line, or before the trailing space of the last byte. The next line is then a new header. Bytes already written stay written, and no rec_done_o is given. A line end before the first address digit, such as a blank line, is ignored.
- R10: ch_ready_o is low in exactly the cycles in which mem_we_o is high.
- R11: On a beat with ch_eol_i high, the value of ch_data_i has no effect on parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_valid_i | input | 1 | Character beat offered |
| ch_data_i | input | 8 | ASCII character code |
| ch_eol_i | input | 1 | Beat is a line end (character ignored) |
| ch_ready_o | output | 1 | Loader can accept a beat |
| mem_addr_o | output | 16 | Write address |
| mem_data_o | output | 8 | Write data byte |
| mem_we_o | output | 1 | Write strobe, one cycle per byte |
| rec_done_o | output | 1 | Record completed pulse |
| rec_err_o | output | 1 | Malformed record pulse |

## Verification
The bench builds the loader with its default 4-digit address and 1-digit count. At that size every one of the 256 character codes can be offered as an address digit, and every count value from 0 to 15 can be run as a full record. The count sweep starts near the top of the 16-bit space so that address wrap is reached. Directed lines cover each way a record can go wrong, and they confirm that a line end arriving with a digit-like code on the data bus is still treated as a line end. The bench also checks the exact cycle of the write strobe and the done pulse.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_TOP   = 8'h46;
  localparam int unsigned TBL_N   = 23;

  typedef enum logic [3:0] {
    ST_ADDR, ST_SP, ST_CNT, ST_HCMT, ST_HI, ST_LO, ST_SEP, ST_TAIL, ST_DROP
  } pst_e;

  // table entry: {valid, nibble}
  function automatic logic [4:0] hex_entry(input int unsigned idx);
    if (idx < 10) return {1'b1, 4'(idx)};
    else if (idx >= 17 && idx < TBL_N) return {1'b1, 4'(idx - 7)};
    else return 5'b0;
  endfunction
endpackage

// File: rtl/hexrec_decode.sv
module hexrec_decode
  import hexrec_pkg::*;
(
  input  logic [7:0] ch_i,
  output logic       ok_o,
  output logic [3:0] nib_o
);
  logic [4:0] tbl [TBL_N];
  logic [4:0] off;
  logic       in_rng;
  logic [4:0] ent;

  for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
    assign tbl[g] = hex_entry(g);
  end

  assign in_rng = (ch_i >= CH_ZERO) && (ch_i <= CH_TOP);
  assign off    = 5'(ch_i - CH_ZERO);
  assign ent    = in_rng ? tbl[off] : 5'b0;
  assign ok_o   = ent[4];
  assign nib_o  = ent[3:0];
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int ADDR_DIGITS = 4,
  parameter int CNT_DIGITS  = 1,
  localparam int ADDR_W = 4 * ADDR_DIGITS,
  localparam int CNT_W  = 4 * CNT_DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [7:0]        ch_i,
  input  logic              eol_i,
  input  logic              hex_ok_i,
  input  logic [3:0]        hex_nib_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_req_o,
  output logic              err_req_o
);
  localparam int MAXD  = (ADDR_DIGITS > CNT_DIGITS) ? ADDR_DIGITS : CNT_DIGITS;
  localparam int IDX_W = $clog2(MAXD + 1);
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_DIGITS - 1);
  localparam logic [IDX_W-1:0] CNT_LAST  = IDX_W'(CNT_DIGITS - 1);

  pst_e              st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        hi_q, hi_d;

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  addr_d = addr_q;
    cnt_d = cnt_q;  hi_d = hi_q;
    wr_req_o = 1'b0;  done_req_o = 1'b0;  err_req_o = 1'b0;
    if (beat_i) begin
      unique case (st_q)
        ST_ADDR: begin
          if (eol_i) begin
            err_req_o = (idx_q != '0);   // blank line is harmless
            idx_d = '0;
          end else if (hex_ok_i) begin
            addr_d = (addr_q << 4) | ADDR_W'(hex_nib_i);
            if (idx_q == ADDR_LAST) begin
              idx_d = '0;
              st_d  = ST_SP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            err_req_o = 1'b1;  idx_d = '0;  st_d = ST_DROP;
          end
        end
        ST_HCMT: begin
          if (eol_i) begin
            if (cnt_q == '0) begin
              done_req_o = 1'b1;
              st_d = ST_ADDR;
            end else begin
              st_d = ST_HI;
            end
          end
        end
        ST_TAIL, ST_DROP: begin
          if (eol_i) st_d = ST_ADDR;
        end
        default: begin
          if (eol_i) begin
            err_req_o = 1'b1;  idx_d = '0;  st_d = ST_ADDR;
          end else if (st_q == ST_SP || st_q == ST_SEP) begin
            if (ch_i != CH_SPACE) begin
              err_req_o = 1'b1;  st_d = ST_DROP;
            end else if (st_q == ST_SP) begin
              st_d = ST_CNT;
            end else if (cnt_q == '0) begin
              done_req_o = 1'b1;  st_d = ST_TAIL;
            end else begin
              st_d = ST_HI;
            end
          end else if (!hex_ok_i) begin
            err_req_o = 1'b1;  idx_d = '0;  st_d = ST_DROP;
          end else if (st_q == ST_CNT) begin
            cnt_d = (cnt_q << 4) | CNT_W'(hex_nib_i);
            if (idx_q == CNT_LAST) begin
              idx_d = '0;  st_d = ST_HCMT;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else if (st_q == ST_HI) begin
            hi_d = hex_nib_i;  st_d = ST_LO;
          end else begin
            wr_req_o = 1'b1;
            addr_d = addr_q + 1'b1;
            cnt_d  = cnt_q - 1'b1;
            st_d   = ST_SEP;
          end
        end
      endcase
    end
  end

  assign wr_addr_o = addr_q;
  assign wr_data_o = {hi_q, hex_nib_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_ADDR;  idx_q <= '0;  addr_q <= '0;  cnt_q <= '0;  hi_q <= '0;
    end else begin
      st_q <= st_d;  idx_q <= idx_d;  addr_q <= addr_d;  cnt_q <= cnt_d;  hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/hexrec_wr_stage.sv
module hexrec_wr_stage #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              done_req_i,
  input  logic              err_req_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              done_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o <= 1'b0;  mem_addr_o <= '0;  mem_data_o <= '0;
      done_o <= 1'b0;  err_o <= 1'b0;
    end else begin
      mem_we_o <= wr_req_i;
      done_o   <= done_req_i;
      err_o    <= err_req_i;
      if (wr_req_i) begin
        mem_addr_o <= wr_addr_i;
        mem_data_o <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
  parameter int ADDR_DIGITS = 4,
  parameter int CNT_DIGITS  = 1,
  localparam int ADDR_W = 4 * ADDR_DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ch_valid_i,
  input  logic [7:0]        ch_data_i,
  input  logic              ch_eol_i,
  output logic              ch_ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              mem_we_o,
  output logic              rec_done_o,
  output logic              rec_err_o
);
  logic              beat, hex_ok, wr_req, done_req, err_req;
  logic [3:0]        hex_nib;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  // write port busy blocks the stream
  assign ch_ready_o = !mem_we_o;
  assign beat       = ch_valid_i && ch_ready_o;

  hexrec_decode u_dec (
    .ch_i  (ch_data_i),
    .ok_o  (hex_ok),
    .nib_o (hex_nib)
  );

  hexrec_parser #(.ADDR_DIGITS(ADDR_DIGITS), .CNT_DIGITS(CNT_DIGITS)) u_parse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (beat),
    .ch_i       (ch_data_i),
    .eol_i      (ch_eol_i),
    .hex_ok_i   (hex_ok),
    .hex_nib_i  (hex_nib),
    .wr_req_o   (wr_req),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .done_req_o (done_req),
    .err_req_o  (err_req)
  );

  hexrec_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_req),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .done_req_i (done_req),
    .err_req_i  (err_req),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o),
    .done_o     (rec_done_o),
    .err_o      (rec_err_o)
  );
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ch_valid_i,
  input logic ch_eol_i,
  input logic ch_ready_o,
  input logic mem_we_o,
  input logic rec_done_o,
  input logic rec_err_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_quiet_in_reset: assert (!mem_we_o && !rec_done_o && !rec_err_o)
        else $error("r1 outputs active in reset");
    end
  end

  a_r4_we_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  a_r4_we_follows_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(ch_valid_i && ch_ready_o && !ch_eol_i));

  a_r5_done_not_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_done_o |-> !mem_we_o);

  a_r9_done_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rec_done_o && rec_err_o));

  a_r7_err_follows_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err_o |-> $past(ch_valid_i && ch_ready_o));
endmodule

bind hexrec_loader hexrec_loader_chk u_chk (.*);

// File: tb/tb_hexrec_loader.sv
module tb_hexrec_loader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        ch_valid_i = 1'b0;
  logic [7:0]  ch_data_i = 8'h00;
  logic        ch_eol_i = 1'b0;
  logic        ch_ready_o, mem_we_o, rec_done_o, rec_err_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  int total = 0, bad = 0;
  int wr_n = 0, done_n = 0, err_n = 0, rdy_bad = 0;
  logic [15:0] wa [512];
  logic [7:0]  wd [512];

  always #5 clk_i = ~clk_i;

  hexrec_loader dut (.*);

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_we_o && wr_n < 512) begin
        wa[wr_n] = mem_addr_o;
        wd[wr_n] = mem_data_o;
      end
      if (mem_we_o) wr_n++;
      if (mem_we_o == ch_ready_o) rdy_bad++;
      if (rec_done_o) done_n++;
      if (rec_err_o) err_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexch(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  task automatic send(input logic [7:0] c, input logic e);
    @(negedge clk_i);
    while (!ch_ready_o) @(negedge clk_i);
    ch_valid_i = 1'b1;  ch_data_i = c;  ch_eol_i = e;
    @(posedge clk_i);
    #1 ch_valid_i = 1'b0;  ch_eol_i = 1'b0;
  endtask

  task automatic put(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i], 1'b0);
  endtask

  task automatic eol(input logic [7:0] c);
    send(c, 1'b1);
  endtask

  task automatic put_hex(input int v, input int nd);
    for (int i = nd - 1; i >= 0; i--) send(hexch((v >> (4 * i)) & 15), 1'b0);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, d0, e0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ch_ready_o && !mem_we_o && !rec_done_o && !rec_err_o, "R1 reset outputs",
        {ch_ready_o, mem_we_o, rec_done_o, rec_err_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7/R2 sweep every code as leading address digit
    for (int c = 0; c < 256; c++) begin
      bit v;
      int nib;
      v = (c >= 48 && c <= 57) || (c >= 65 && c <= 70);
      nib = (c <= 57) ? c - 48 : c - 55;
      w0 = wr_n; d0 = done_n; e0 = err_n;
      send(8'(c), 1'b0);
      put("000 1 h");
      eol(8'h41);
      if (v) begin
        put("5A ");
        eol(8'h41);
      end
      settle();
      chk(err_n - e0 == (v ? 0 : 1), $sformatf("R7 code %0h err", c), err_n - e0, v ? 0 : 1);
      if (v) chk(wr_n - w0 == 1 && done_n - d0 == 1 && wa[w0] == 16'(nib << 12) && wd[w0] == 8'h5A,
                 $sformatf("R2 code %0h addr", c), wa[w0], nib << 12);
      else   chk(wr_n == w0 && done_n == d0, $sformatf("R7 code %0h no write", c), wr_n - w0, 0);
    end

    // R3/R4/R5/R6/R2 every count, base near top for wrap
    for (int n = 0; n < 16; n++) begin
      int base, mis;
      base = 16'hFFF4 + n;
      w0 = wr_n; d0 = done_n; e0 = err_n;
      put_hex(base, 4); put(" "); send(hexch(n), 1'b0); put(" cmt 12 zz");
      eol(8'h30);
      if (n > 0) begin
        for (int k = 0; k < n; k++) begin
          put_hex((n * 16 + k * 37 + 3) & 255, 2);
          put(" ");
        end
        put("; 9A zz -");
        eol(8'h31);
      end
      settle();
      chk(wr_n - w0 == n, n == 0 ? "R6 count zero writes" : "R3 write count", wr_n - w0, n);
      chk(done_n - d0 == 1 && err_n == e0, n == 0 ? "R6 done" : "R5 done once",
          done_n - d0, 1);
      mis = 0;
      for (int k = 0; k < n; k++)
        if (wa[w0 + k] != 16'((base + k) & 16'hFFFF) || wd[w0 + k] != 8'((n * 16 + k * 37 + 3) & 255))
          mis++;
      chk(mis == 0, "R2 R4 addr/data sequence", mis, 0);
    end

    // R4/R10/R5 exact timing
    put("4000 2 x"); eol(8'h41);
    send(8'h31, 1'b0); send(8'h32, 1'b0);
    @(negedge clk_i);
    chk(mem_we_o && !ch_ready_o && mem_addr_o == 16'h4000 && mem_data_o == 8'h12,
        "R4 R10 write cycle", {mem_we_o, ch_ready_o, mem_data_o}, 10'h212);
    @(negedge clk_i);
    chk(!mem_we_o && ch_ready_o, "R4 R10 write one cycle", {mem_we_o, ch_ready_o}, 2'b01);
    put(" 34 ");
    @(negedge clk_i);
    chk(rec_done_o, "R5 done cycle", rec_done_o, 1);
    @(negedge clk_i);
    chk(!rec_done_o, "R5 done one cycle", rec_done_o, 0);
    eol(8'h41);
    settle();

    // R8 wrong data separator, then recovery
    w0 = wr_n; d0 = done_n; e0 = err_n;
    put("1000 2 c"); eol(8'h41); put("11-22 "); eol(8'h41);
    settle();
    chk(wr_n - w0 == 1 && err_n - e0 == 1 && done_n == d0, "R8 data separator", err_n - e0, 1);
    w0 = wr_n; e0 = err_n;
    put("1234X5"); eol(8'h41);
    settle();
    chk(err_n - e0 == 1 && wr_n == w0, "R8 header separator", err_n - e0, 1);

    // R9 missing trailing space on last byte
    w0 = wr_n; d0 = done_n; e0 = err_n;
    put("2000 1"); eol(8'h41); put("AB"); eol(8'h41);
    settle();
    chk(wr_n - w0 == 1 && err_n - e0 == 1 && done_n == d0, "R9 no trailing space", err_n - e0, 1);

    // R9 R11 short data line, line end carries a digit code
    w0 = wr_n; d0 = done_n; e0 = err_n;
    put("7000 3 c"); eol(8'h41); put("01 02 "); eol(8'h34);
    settle();
    chk(wr_n - w0 == 2 && err_n - e0 == 1 && done_n == d0, "R9 R11 short line", wr_n - w0, 2);

    // R9 line end inside address, blank lines ignored, next record clean
    w0 = wr_n; d0 = done_n; e0 = err_n;
    put("12"); eol(8'h41);
    settle();
    chk(err_n - e0 == 1, "R9 eol in address", err_n - e0, 1);
    e0 = err_n;
    eol(8'h35); eol(8'h20);
    put("3000 1"); eol(8'h37); put("C3 "); eol(8'h41);
    settle();
    chk(err_n == e0 && done_n - d0 == 1 && wa[wr_n - 1] == 16'h3000 && wd[wr_n - 1] == 8'hC3,
        "R9 blank lines ignored", err_n - e0, 0);

    // R7 lowercase letter in data
    w0 = wr_n; e0 = err_n;
    put("3100 1"); eol(8'h41); put("a5 "); eol(8'h41);
    settle();
    chk(err_n - e0 == 1 && wr_n == w0, "R7 lowercase rejected", err_n - e0, 1);

    // R1 reset mid record, then a fresh record
    put("5000 3"); eol(8'h41); put("11 ");
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(ch_ready_o && !mem_we_o && !rec_done_o && !rec_err_o, "R1 mid reset outputs",
        {ch_ready_o, mem_we_o, rec_done_o, rec_err_o}, 4'b1000);
    rst_ni = 1'b1;
    w0 = wr_n; d0 = done_n; e0 = err_n;
    put("6000 1"); eol(8'h41); put("77 "); eol(8'h41);
    settle();
    chk(wr_n - w0 == 1 && done_n - d0 == 1 && err_n == e0 && wa[w0] == 16'h6000,
        "R1 restart after reset", wa[w0], 16'h6000);

    chk(rdy_bad == 0, "R10 ready vs write", rdy_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule